// File: doc/BRIEF.md
# Page Block-State Controller

This block decides whether one page of a protected page cache may be marked as blocked, and marks it when it may. It keeps a small metadata table with one entry per page. Each entry holds a valid bit, a page-type code, a blocked bit and an in-use (busy) bit. A privileged agent sends a request that carries a byte address and a privilege level. The block runs a fixed, prioritised series of checks. It then reports either a fault class, or a status code with a zero flag and a carry flag. The blocked bit of the target entry is set only when every check succeeds.

Requests arrive on a valid/ready port, and the block accepts one only while it is idle. The entry is read in the cycle after acceptance and evaluated in the cycle after that. On that second edge the table is written and a one-cycle result strobe is raised. A separate load port writes whole entries, which lets the surrounding logic or a bench set up page state. An epoch-lock input is sampled with each request. While it is high, any request that passes the fault checks gets a retry-later status.

Page-type codes: 0 enclave-control, 1 thread-control, 2 regular, 3 version-array, 4 trimmed, 5 shadow-stack-first, 6 shadow-stack-rest, 7 reserved.

Top module: `pgblk_ctrl`

## Requirements
- R1: After reset `req_ready_o` is 1 and `res_valid_o` is 0, and every table entry is cleared: valid, blocked and busy are all 0 and the type is 0.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 in the following cycle. `res_valid_o` is 1 for exactly one cycle, starting two edges after acceptance.
- R3: A request with a privilege level other than 0 returns fault 1 (general protection) with status 0 and both flags 0. It changes no table state.
- R4: An address whose low `PAGE_SHIFT` bits are not zero returns fault 1. This takes precedence over the range check. Status and flags are 0.
- R5: An aligned address outside [BASE_ADDR, BASE_ADDR + N_PAGES·2^PAGE_SHIFT) returns fault 2 (page fault) with status 0 and both flags 0. Fault code 3 is never produced.
- R6: When `epoch_lock_i` is 1 at acceptance and no fault applies, the result is status 6 with zf=1 and cf=0. This check precedes the busy check, and the entry is left unchanged.
- R7: A busy entry returns status 1 (page conflict) with zf=1 and cf=0, even if the entry is not valid.
- R8: A non-valid entry that is not busy returns status 2 (invalid) with zf=1 and cf=0.
- R9: Only types 1, 2, 4, 5 and 6 can be blocked. Type 0 returns status 4 (control page), and types 3 and 7 return status 3 (not blockable). Both cases give cf=1 and zf=0.
- R10: A blockable entry whose blocked bit is already set returns status 5 with cf=1 and zf=0, and the entry stays unchanged.
- R11: Otherwise the result is fault 0, status 0 and both flags 0, and the entry's blocked bit is set. A later request to the same page therefore returns status 5.
- R12: A load with `ld_en_i`=1 replaces the whole entry at `ld_idx_i` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to accept |
| req_addr_i | input | ADDR_W | Target byte address |
| req_priv_i | input | 2 | Requester privilege level |
| epoch_lock_i | input | 1 | Epoch tracking in progress on the control page |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_fault_o | output | 2 | 0 none, 1 general protection, 2 page fault |
| res_status_o | output | 3 | Status code 0..6 |
| res_zf_o | output | 1 | Zero flag |
| res_cf_o | output | 1 | Carry flag |
| ld_en_i | input | 1 | Entry load strobe |
| ld_idx_i | input | $clog2(N_PAGES) | Entry index to load |
| ld_valid_i | input | 1 | Loaded valid bit |
| ld_type_i | input | 3 | Loaded page-type code |
| ld_blocked_i | input | 1 | Loaded blocked bit |
| ld_busy_i | input | 1 | Loaded busy bit |

## Verification
The bench builds the block with BASE_ADDR = 0x0004_0000 and N_PAGES = 8, so the table is half its default size and starts above address zero. With these values, the page just below the base and the page just past the last entry are both out of range, and both ends of the range check can be reached. Eight entries are enough to give each blockable type, the control type and a non-blockable type its own page. A busy page and a reloaded page can then be checked alongside them without reusing state.

// File: rtl/pgblk_pkg.sv
// Package pgblk_pkg
// Shared encodings for the page block-state controller: entry layout,
// fault classes, status codes and page-type codes.
package pgblk_pkg;

    typedef struct packed {
        logic       valid;
        logic [2:0] ptype;
        logic       blocked;
        logic       busy;
    } pg_entry_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_PF   = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_OK       = 3'd0,
        ST_CONFLICT = 3'd1,
        ST_INVALID  = 3'd2,
        ST_NOBLOCK  = 3'd3,
        ST_CTRLPG   = 3'd4,
        ST_ALREADY  = 3'd5,
        ST_EPOCH    = 3'd6
    } status_e;

    localparam logic [2:0] PT_CTRL  = 3'd0;
    localparam logic [2:0] PT_THRD  = 3'd1;
    localparam logic [2:0] PT_REG   = 3'd2;
    localparam logic [2:0] PT_TRIM  = 3'd4;
    localparam logic [2:0] PT_SSFST = 3'd5;
    localparam logic [2:0] PT_SSRST = 3'd6;

    // True for the five page types that may be blocked.
    function automatic logic type_blockable(input logic [2:0] t);
        return (t == PT_THRD) || (t == PT_REG) || (t == PT_TRIM) ||
               (t == PT_SSFST) || (t == PT_SSRST);
    endfunction

endpackage

// File: rtl/pgblk_decode.sv
// Module pgblk_decode
// Combinational request screening: privilege, alignment and range checks,
// plus the table index for in-range addresses.
// Assumes N_PAGES * 2^PAGE_SHIFT fits in ADDR_W+1 bits.
module pgblk_decode
    import pgblk_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                N_PAGES    = 16,
    parameter int                PAGE_SHIFT = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h0010_0000,
    localparam int               IDX_W      = $clog2(N_PAGES)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        priv_i,
    output fault_e            fault_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(N_PAGES) << PAGE_SHIFT;

    logic [ADDR_W-1:0] offset;
    logic              in_range;

    // Offset from the base and membership of the protected range.
    always_comb begin
        offset   = addr_i - BASE_ADDR;
        in_range = ({1'b0, addr_i} >= {1'b0, BASE_ADDR}) &&
                   ({1'b0, offset} < SPAN);
        idx_o    = offset[PAGE_SHIFT +: IDX_W];
    end

    // Fault priority: privilege, then alignment, then range.
    always_comb begin
        if (priv_i != 2'd0)
            fault_o = FLT_GP;
        else if (addr_i[PAGE_SHIFT-1:0] != '0)
            fault_o = FLT_GP;
        else if (!in_range)
            fault_o = FLT_PF;
        else
            fault_o = FLT_NONE;
    end

endmodule

// File: rtl/pgblk_meta.sv
// Module pgblk_meta
// Per-page metadata table with a registered read port, a whole-entry
// load port and a set-blocked port. Load wins over set on the same entry.
// Assumes at most one read per cycle; a read sees the pre-edge contents.
module pgblk_meta
    import pgblk_pkg::*;
#(
    parameter int  N_PAGES = 16,
    localparam int IDX_W   = $clog2(N_PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output pg_entry_t        rd_q_o,
    input  logic             ld_en_i,
    input  logic [IDX_W-1:0] ld_idx_i,
    input  pg_entry_t        ld_data_i,
    input  logic             set_en_i,
    input  logic [IDX_W-1:0] set_idx_i
);

    pg_entry_t mem [N_PAGES];

    for (genvar g = 0; g < N_PAGES; g++) begin : g_entry
        // One entry register: clear, load or set its blocked bit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (ld_en_i && (ld_idx_i == IDX_W'(g)))
                mem[g] <= ld_data_i;
            else if (set_en_i && (set_idx_i == IDX_W'(g)))
                mem[g].blocked <= 1'b1;
        end
    end

    // Registered read of the requested entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q_o <= '0;
        else if (rd_en_i)
            rd_q_o <= mem[rd_idx_i];
    end

endmodule

// File: rtl/pgblk_eval.sv
// Module pgblk_eval
// Combinational verdict on a screened request and its entry: status,
// flags and whether to set the blocked bit. Checks are in priority order.
module pgblk_eval
    import pgblk_pkg::*;
(
    input  fault_e    fault_i,
    input  logic      epoch_i,
    input  pg_entry_t entry_i,
    output status_e   status_o,
    output logic      zf_o,
    output logic      cf_o,
    output logic      set_o
);

    // Priority chain; every path starts from cleared flags and success.
    always_comb begin
        status_o = ST_OK;
        zf_o     = 1'b0;
        cf_o     = 1'b0;
        set_o    = 1'b0;
        if (fault_i != FLT_NONE) begin
            status_o = ST_OK;
        end else if (epoch_i) begin
            status_o = ST_EPOCH;
            zf_o     = 1'b1;
        end else if (entry_i.busy) begin
            status_o = ST_CONFLICT;
            zf_o     = 1'b1;
        end else if (!entry_i.valid) begin
            status_o = ST_INVALID;
            zf_o     = 1'b1;
        end else if (!type_blockable(entry_i.ptype)) begin
            cf_o     = 1'b1;
            status_o = (entry_i.ptype == PT_CTRL) ? ST_CTRLPG : ST_NOBLOCK;
        end else if (entry_i.blocked) begin
            cf_o     = 1'b1;
            status_o = ST_ALREADY;
        end else begin
            set_o    = 1'b1;
        end
    end

endmodule

// File: rtl/pgblk_ctrl.sv
// Module pgblk_ctrl
// Top of the page block-state controller. Accepts one request while idle,
// reads the entry on the accept edge, evaluates and writes on the next
// edge, and raises a one-cycle result strobe.
// Assumes the load port is not used for the entry under evaluation.
module pgblk_ctrl
    import pgblk_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                N_PAGES    = 16,
    parameter int                PAGE_SHIFT = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 32'h0010_0000,
    localparam int               IDX_W      = $clog2(N_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [1:0]        req_priv_i,
    input  logic              epoch_lock_i,
    output logic              res_valid_o,
    output logic [1:0]        res_fault_o,
    output logic [2:0]        res_status_o,
    output logic              res_zf_o,
    output logic              res_cf_o,
    input  logic              ld_en_i,
    input  logic [IDX_W-1:0]  ld_idx_i,
    input  logic              ld_valid_i,
    input  logic [2:0]        ld_type_i,
    input  logic              ld_blocked_i,
    input  logic              ld_busy_i
);

    typedef enum logic {S_IDLE, S_EVAL} state_e;

    state_e           state_q;
    logic             accept;
    fault_e           dec_fault;
    logic [IDX_W-1:0] dec_idx;
    fault_e           fault_q;
    logic [IDX_W-1:0] idx_q;
    logic             epoch_q;
    pg_entry_t        entry_q;
    pg_entry_t        ld_data;
    status_e          ev_status;
    logic             ev_zf;
    logic             ev_cf;
    logic             ev_set;
    logic             set_en;

    // Handshake and write-enable decode.
    always_comb begin
        req_ready_o = (state_q == S_IDLE);
        accept      = req_valid_i && req_ready_o;
        set_en      = (state_q == S_EVAL) && ev_set;
        ld_data     = '{valid: ld_valid_i, ptype: ld_type_i,
                        blocked: ld_blocked_i, busy: ld_busy_i};
    end

    pgblk_decode #(
        .ADDR_W(ADDR_W), .N_PAGES(N_PAGES),
        .PAGE_SHIFT(PAGE_SHIFT), .BASE_ADDR(BASE_ADDR)
    ) i_decode (
        .addr_i  (req_addr_i),
        .priv_i  (req_priv_i),
        .fault_o (dec_fault),
        .idx_o   (dec_idx)
    );

    pgblk_meta #(.N_PAGES(N_PAGES)) i_meta (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (accept),
        .rd_idx_i  (dec_idx),
        .rd_q_o    (entry_q),
        .ld_en_i   (ld_en_i),
        .ld_idx_i  (ld_idx_i),
        .ld_data_i (ld_data),
        .set_en_i  (set_en),
        .set_idx_i (idx_q)
    );

    pgblk_eval i_eval (
        .fault_i  (fault_q),
        .epoch_i  (epoch_q),
        .entry_i  (entry_q),
        .status_o (ev_status),
        .zf_o     (ev_zf),
        .cf_o     (ev_cf),
        .set_o    (ev_set)
    );

    // Capture the screened request on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= FLT_NONE;
            idx_q   <= '0;
            epoch_q <= 1'b0;
        end else if (accept) begin
            fault_q <= dec_fault;
            idx_q   <= dec_idx;
            epoch_q <= epoch_lock_i;
        end
    end

    // Two-state sequencer: idle, then one evaluation cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else if (accept)
            state_q <= S_EVAL;
        else if (state_q == S_EVAL)
            state_q <= S_IDLE;
    end

    // Result registers and the one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o  <= 1'b0;
            res_fault_o  <= 2'd0;
            res_status_o <= 3'd0;
            res_zf_o     <= 1'b0;
            res_cf_o     <= 1'b0;
        end else begin
            res_valid_o <= (state_q == S_EVAL);
            if (state_q == S_EVAL) begin
                res_fault_o  <= fault_q;
                res_status_o <= ev_status;
                res_zf_o     <= ev_zf;
                res_cf_o     <= ev_cf;
            end
        end
    end

endmodule

// File: rtl/pgblk_checker.sv
// Module pgblk_checker
// Port-level properties of pgblk_ctrl, attached with the bind below.
module pgblk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid_i,
    input logic       req_ready_o,
    input logic       res_valid_o,
    input logic [1:0] res_fault_o,
    input logic [2:0] res_status_o,
    input logic       res_zf_o,
    input logic       res_cf_o
);

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> !req_ready_o);

    a_r2_result_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o) |=> ##1 res_valid_o);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);

    a_r3_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_fault_o != 2'd0) |->
            (res_status_o == 3'd0 && !res_zf_o && !res_cf_o));

    a_r5_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (res_fault_o != 2'd3));

    a_r6_epoch_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_status_o == 3'd6) |-> (res_zf_o && !res_cf_o));

    a_r9_noblock_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && (res_status_o == 3'd3 || res_status_o == 3'd4)) |->
            (res_cf_o && !res_zf_o));

    a_r10_already_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_status_o == 3'd5) |-> (res_cf_o && !res_zf_o));

    a_r11_success_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_fault_o == 2'd0 && res_status_o == 3'd0) |->
            (!res_zf_o && !res_cf_o));

endmodule

bind pgblk_ctrl pgblk_checker i_pgblk_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .res_valid_o  (res_valid_o),
    .res_fault_o  (res_fault_o),
    .res_status_o (res_status_o),
    .res_zf_o     (res_zf_o),
    .res_cf_o     (res_cf_o)
);

// File: tb/test_pgblk_ctrl.sv
// Scoreboard bench for pgblk_ctrl: the driver queues expected results,
// the monitor compares them when the result strobe appears.
module test_pgblk_ctrl;

    localparam int              AW    = 32;
    localparam int              NP    = 8;
    localparam int              PS    = 12;
    localparam logic [AW-1:0]   BASE  = 32'h0004_0000;
    localparam int              IW    = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic          req_ready_o;
    logic [AW-1:0] req_addr_i = '0;
    logic [1:0]    req_priv_i = '0;
    logic          epoch_lock_i = 1'b0;
    logic          res_valid_o;
    logic [1:0]    res_fault_o;
    logic [2:0]    res_status_o;
    logic          res_zf_o;
    logic          res_cf_o;
    logic          ld_en_i = 1'b0;
    logic [IW-1:0] ld_idx_i = '0;
    logic          ld_valid_i = 1'b0;
    logic [2:0]    ld_type_i = '0;
    logic          ld_blocked_i = 1'b0;
    logic          ld_busy_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [1:0] f;
        logic [2:0] s;
        logic       z;
        logic       c;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #5 clk = ~clk;

    pgblk_ctrl #(.ADDR_W(AW), .N_PAGES(NP), .PAGE_SHIFT(PS), .BASE_ADDR(BASE))
    i_pgblk_ctrl (.*);

    function automatic logic [AW-1:0] pg(input int i);
        return BASE + (AW'(i) << PS);
    endfunction

    task automatic check(input bit ok, input string req, input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    // Monitor: compare every result strobe against the queue head.
    always @(negedge clk) begin
        if (rst_n && res_valid_o && !done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected result strobe", "no strobe");
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(res_fault_o == e.f && res_status_o == e.s &&
                      res_zf_o == e.z && res_cf_o == e.c, e.req,
                      $sformatf("f=%0d s=%0d zf=%0d cf=%0d", res_fault_o, res_status_o, res_zf_o, res_cf_o),
                      $sformatf("f=%0d s=%0d zf=%0d cf=%0d", e.f, e.s, e.z, e.c));
            end
        end
    end

    // Driver: one request, starting and ending at a falling edge.
    task automatic issue(input logic [AW-1:0] a, input logic [1:0] p, input bit ep,
                         input logic [1:0] f, input logic [2:0] s, input bit z, input bit c,
                         input string req);
        exp_t e;
        e = '{f: f, s: s, z: z, c: c, req: req};
        sb.push_back(e);
        req_addr_i   = a;
        req_priv_i   = p;
        epoch_lock_i = ep;
        req_valid_i  = 1'b1;
        @(posedge clk);
        #1 req_valid_i = 1'b0;
        epoch_lock_i = 1'b0;
        @(negedge clk);
        check(!req_ready_o && !res_valid_o, "R2",
              $sformatf("ready=%0d valid=%0d", req_ready_o, res_valid_o), "ready=0 valid=0");
        @(negedge clk);
    endtask

    task automatic load(input int i, input bit v, input logic [2:0] t, input bit b, input bit bz);
        ld_idx_i     = IW'(i);
        ld_valid_i   = v;
        ld_type_i    = t;
        ld_blocked_i = b;
        ld_busy_i    = bz;
        ld_en_i      = 1'b1;
        @(posedge clk);
        #1 ld_en_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset, table cleared
        check(req_ready_o && !res_valid_o, "R1",
              $sformatf("ready=%0d valid=%0d", req_ready_o, res_valid_o), "ready=1 valid=0");
        issue(pg(0), 2'd0, 0, 2'd0, 3'd2, 1, 0, "R1");
        issue(pg(7), 2'd0, 0, 2'd0, 3'd2, 1, 0, "R8");

        // R12: set up entries through the load port
        load(0, 1, 3'd2, 0, 0);
        load(1, 1, 3'd1, 0, 0);
        load(2, 1, 3'd4, 0, 0);
        load(3, 1, 3'd5, 0, 0);
        load(4, 1, 3'd6, 0, 0);
        load(5, 1, 3'd0, 0, 0);
        load(6, 1, 3'd3, 0, 0);
        load(7, 1, 3'd2, 0, 1);

        // R3: refused privilege, no state change (success follows)
        issue(pg(0), 2'd3, 0, 2'd1, 3'd0, 0, 0, "R3");
        issue(pg(0), 2'd1, 0, 2'd1, 3'd0, 0, 0, "R3");
        issue(pg(0), 2'd0, 0, 2'd0, 3'd0, 0, 0, "R11");
        issue(pg(0), 2'd0, 0, 2'd0, 3'd5, 0, 1, "R11");
        issue(pg(0), 2'd0, 0, 2'd0, 3'd5, 0, 1, "R10");

        // R4: misalignment, including outside the range
        issue(pg(1) + 32'h10, 2'd0, 0, 2'd1, 3'd0, 0, 0, "R4");
        issue(32'h0000_0010, 2'd0, 0, 2'd1, 3'd0, 0, 0, "R4");
        issue(pg(NP) + 32'h800, 2'd0, 0, 2'd1, 3'd0, 0, 0, "R4");

        // R5: both ends of the range
        issue(pg(NP), 2'd0, 0, 2'd2, 3'd0, 0, 0, "R5");
        issue(BASE - 32'h1000, 2'd0, 0, 2'd2, 3'd0, 0, 0, "R5");
        issue(32'h0000_0000, 2'd0, 1, 2'd2, 3'd0, 0, 0, "R5");

        // R7 / R6: busy page, epoch lock precedence
        issue(pg(7), 2'd0, 0, 2'd0, 3'd1, 1, 0, "R7");
        issue(pg(7), 2'd0, 1, 2'd0, 3'd6, 1, 0, "R6");
        load(7, 0, 3'd2, 0, 1);
        issue(pg(7), 2'd0, 0, 2'd0, 3'd1, 1, 0, "R7");

        // R6: epoch lock leaves a blockable page untouched
        issue(pg(2), 2'd0, 1, 2'd0, 3'd6, 1, 0, "R6");
        issue(pg(5), 2'd0, 1, 2'd0, 3'd6, 1, 0, "R6");

        // R9 / R11: blockable types succeed, others are refused
        issue(pg(1), 2'd0, 0, 2'd0, 3'd0, 0, 0, "R9");
        issue(pg(2), 2'd0, 0, 2'd0, 3'd0, 0, 0, "R9");
        issue(pg(3), 2'd0, 0, 2'd0, 3'd0, 0, 0, "R9");
        issue(pg(4), 2'd0, 0, 2'd0, 3'd0, 0, 0, "R9");
        issue(pg(5), 2'd0, 0, 2'd0, 3'd4, 0, 1, "R9");
        issue(pg(6), 2'd0, 0, 2'd0, 3'd3, 0, 1, "R9");
        load(6, 1, 3'd7, 0, 0);
        issue(pg(6), 2'd0, 0, 2'd0, 3'd3, 0, 1, "R9");
        issue(pg(4), 2'd0, 0, 2'd0, 3'd5, 0, 1, "R10");

        // R12: reload replaces the whole entry
        load(0, 1, 3'd2, 0, 0);
        issue(pg(0), 2'd0, 0, 2'd0, 3'd0, 0, 0, "R12");
        load(0, 0, 3'd2, 1, 0);
        issue(pg(0), 2'd0, 0, 2'd0, 3'd2, 1, 0, "R12");

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R2", $sformatf("%0d pending", sb.size()), "0 pending");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2: actual hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule